// File: doc/BRIEF.md
# Cyclic Counter with Coincidence Flag

This block counts qualified input pulses upward from zero. Two programmable thresholds govern it. The match value raises a coincidence flag when the count steps onto it. The count width is the top of the range: a count event seen while the current value sits at the width returns the counter to zero, emits a one-cycle carry pulse and starts the next lap.

Software loads the current value, the match value and the count width over one shared data bus. Each of the three has its own load strobe, and a load acts on the rising edge of that strobe. Every load is answered one cycle later by an accept or reject pulse. A reject leaves all state unchanged. Two clear inputs, an external one and a software one, stop counting and force the value to zero. An output-disable input keeps the coincidence flag low while it is asserted.

Top module: `cyc_match_counter`

## Requirements
- R1: A synchronous active-low reset sets the current value to 0, the coincidence flag, carry, accept and reject to 0, the match value to 1000 and the count width to 2000.
- R2: A count event occurs in a clock cycle only when the count pulse, the internal count-enable and the external enable are all 1. Each count event raises the current value by one. Without a count event the value holds.
- R3: A count event while the current value is equal to or greater than the count width sets the value to 0. Carry is then 1 for exactly the next cycle, and carry is 0 at all other times.
- R4: The coincidence flag is set by a count event that moves the value onto the match value. It stays set until a wrap, a clear or output-disable.
- R5: While output-disable is 1, the coincidence flag is 0 from the next cycle on and cannot be set.
- R6: While the external clear or the software clear is 1, counting stops, the value is forced to 0 and the coincidence flag is cleared. A current-value load attempted in that cycle is rejected.
- R7: A load acts only on a 0-to-1 transition of its strobe. One cycle later exactly one of accept or reject is 1 for one cycle. A strobe held high causes no further load. If several strobes rise together, current value wins over match value, and match value wins over width; the others are dropped.
- R8: A match-value load is accepted only when the new value is less than the present count width.
- R9: A count-width load is accepted only when the new width is non-zero, at most 999999, and greater than the present match value.
- R10: A current-value load is accepted only when the new value is at most the present count width. It does not alter the coincidence flag.
- R11: The value never exceeds 999999. With width 999999, a count event at 999999 wraps to 0 with carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_pulse | input | 1 | Count pulse, one event per cycle high |
| cnt_en | input | 1 | Internal count-enable |
| ext_en | input | 1 | External enable |
| ext_clr | input | 1 | External clear of the current value |
| sw_clr | input | 1 | Software clear of the current value |
| out_dis | input | 1 | Suppresses and clears the coincidence flag |
| ld_cur | input | 1 | Load strobe for the current value |
| ld_match | input | 1 | Load strobe for the match value |
| ld_width | input | 1 | Load strobe for the count width |
| ld_data | input | CNT_W | Shared load data |
| cur_val | output | CNT_W | Current count value |
| coin | output | 1 | Coincidence flag |
| carry | output | 1 | One-cycle wrap pulse |
| ack | output | 1 | Load accepted, one-cycle pulse |
| nak | output | 1 | Load rejected, one-cycle pulse |

## Verification
The assertion that a rising flag sits on the previous cycle's match value assumes the match value is not reloaded in the same cycle as a count event. The bench never combines those two actions in one cycle. The hold assertion assumes that every change of the value comes from a count event, a current-value load or a clear. Every load in the stimulus is therefore preceded by a cycle with all strobes low, so that each load is a clean single rising edge.

// File: rtl/ccm_pkg.sv
// Package for the cyclic match counter.
// Names the three load strobes and fixes how many there are.
// Assumes: strobe vectors are indexed by ld_sel_e.
package ccm_pkg;
    typedef enum int unsigned {
        LD_CUR   = 0,
        LD_MATCH = 1,
        LD_WIDTH = 2
    } ld_sel_e;

    localparam int NUM_LD = 3;
endpackage

// File: rtl/ccm_edge.sv
// Rising-edge detector, one lane per load strobe.
// Assumes: the strobes are synchronous to clk.
module ccm_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strb,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_lane
        // Remember last cycle's strobe level.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= strb[g];
        end
        assign rise[g] = strb[g] & ~prev_q[g];
    end
endmodule

// File: rtl/ccm_preset.sv
// Preset store: checks each load request, holds the match value and the
// count width, and answers every request with a one-cycle accept/reject.
// Assumes: rise[] holds single-cycle requests from ccm_edge.
module ccm_preset
    import ccm_pkg::*;
#(
    parameter int W     = 20,
    parameter int MAXV  = 999999,
    parameter int DEF_M = 1000,
    parameter int DEF_W = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [NUM_LD-1:0] rise,
    input  logic [W-1:0]      data,
    output logic [W-1:0]      match_q,
    output logic [W-1:0]      width_q,
    output logic              cur_load,
    output logic              ack,
    output logic              nak
);
    localparam logic [W-1:0] MAX_V = W'(MAXV);

    logic req, ok, take_m, take_w;

    // Pick one request by priority and check it against the present settings.
    always_comb begin
        req    = |rise;
        ok     = 1'b0;
        take_m = 1'b0;
        take_w = 1'b0;
        if (rise[LD_CUR]) begin
            ok = !clr && (data <= width_q);
        end else if (rise[LD_MATCH]) begin
            ok     = data < width_q;
            take_m = ok;
        end else if (rise[LD_WIDTH]) begin
            ok     = (data != '0) && (data <= MAX_V) && (data > match_q);
            take_w = ok;
        end
    end

    assign cur_load = rise[LD_CUR] & ok;

    // Store accepted thresholds and raise the answer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= W'(DEF_M);
            width_q <= W'(DEF_W);
            ack     <= 1'b0;
            nak     <= 1'b0;
        end else begin
            ack <= req & ok;
            nak <= req & ~ok;
            if (take_m) match_q <= data;
            if (take_w) width_q <= data;
        end
    end
endmodule

// File: rtl/ccm_core.sv
// Count datapath: increments on a count event, wraps past the width with a
// carry pulse, and keeps the coincidence flag.
// Assumes: cur_load was already checked by ccm_preset.
module ccm_core #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         out_dis,
    input  logic         cur_load,
    input  logic [W-1:0] data,
    input  logic [W-1:0] match_q,
    input  logic [W-1:0] width_q,
    output logic [W-1:0] cur_q,
    output logic         coin_q,
    output logic         carry_q
);
    logic         wrap;
    logic [W-1:0] nxt;
    logic         hit;

    // Work out the wrap condition and the incremented value.
    always_comb begin
        wrap = cur_q >= width_q;
        nxt  = cur_q + 1'b1;
        hit  = step && !cur_load && !wrap && (nxt == match_q);
    end

    // Value and carry register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cur_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            carry_q <= 1'b0;
            if (cur_load) begin
                cur_q <= data;
            end else if (step) begin
                if (wrap) begin
                    cur_q   <= '0;
                    carry_q <= 1'b1;
                end else begin
                    cur_q <= nxt;
                end
            end
        end
    end

    // Coincidence flag: set on stepping onto the match, cleared by wrap or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            coin_q <= 1'b0;
        end else if (out_dis) begin
            coin_q <= 1'b0;
        end else if (step && !cur_load && wrap) begin
            coin_q <= 1'b0;
        end else if (hit) begin
            coin_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cyc_match_counter.sv
// Top of the cyclic match counter: qualifies count events, detects load
// edges and ties the preset store to the count datapath.
// Assumes: all inputs are synchronous to clk.
module cyc_match_counter
    import ccm_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int MAX_VAL = 999999,
    parameter int DEF_M   = 1000,
    parameter int DEF_W   = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_pulse,
    input  logic             cnt_en,
    input  logic             ext_en,
    input  logic             ext_clr,
    input  logic             sw_clr,
    input  logic             out_dis,
    input  logic             ld_cur,
    input  logic             ld_match,
    input  logic             ld_width,
    input  logic [CNT_W-1:0] ld_data,
    output logic [CNT_W-1:0] cur_val,
    output logic             coin,
    output logic             carry,
    output logic             ack,
    output logic             nak
);
    logic [NUM_LD-1:0] strb, rise;
    logic [CNT_W-1:0]  match_q, width_q;
    logic              cur_load, clr, step;

    assign strb[LD_CUR]   = ld_cur;
    assign strb[LD_MATCH] = ld_match;
    assign strb[LD_WIDTH] = ld_width;
    assign clr  = ext_clr | sw_clr;
    assign step = cnt_pulse & cnt_en & ext_en;

    ccm_edge #(.N(NUM_LD)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .strb  (strb),
        .rise  (rise)
    );

    ccm_preset #(.W(CNT_W), .MAXV(MAX_VAL), .DEF_M(DEF_M), .DEF_W(DEF_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .rise     (rise),
        .data     (ld_data),
        .match_q  (match_q),
        .width_q  (width_q),
        .cur_load (cur_load),
        .ack      (ack),
        .nak      (nak)
    );

    ccm_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .step     (step),
        .out_dis  (out_dis),
        .cur_load (cur_load),
        .data     (ld_data),
        .match_q  (match_q),
        .width_q  (width_q),
        .cur_q    (cur_val),
        .coin_q   (coin),
        .carry_q  (carry)
    );
endmodule

// File: rtl/ccm_chk.sv
// Property checker for cyc_match_counter, attached by bind below.
// Assumes: no match load in the same cycle as a count event.
module ccm_chk #(
    parameter int W    = 20,
    parameter int MAXV = 999999
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_pulse,
    input logic         cnt_en,
    input logic         ext_en,
    input logic         ext_clr,
    input logic         sw_clr,
    input logic         out_dis,
    input logic         ld_cur,
    input logic [W-1:0] cur_val,
    input logic [W-1:0] match_q,
    input logic         coin,
    input logic         carry,
    input logic         ack,
    input logic         nak
);
    // R2
    hold_without_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cnt_pulse && cnt_en && ext_en) && !ld_cur && !ext_clr && !sw_clr) |=> $stable(cur_val));

    // R3
    carry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);

    // R3
    carry_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (cur_val == '0));

    // R4
    coin_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coin) |-> (cur_val == $past(match_q)));

    // R5
    coin_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |=> !coin);

    // R6
    clear_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clr || sw_clr) |=> (cur_val == '0 && !coin));

    // R7
    answer_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && nak));

    // R11
    value_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_val <= W'(MAXV));
endmodule

bind cyc_match_counter ccm_chk #(.W(CNT_W), .MAXV(MAX_VAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_pulse (cnt_pulse),
    .cnt_en    (cnt_en),
    .ext_en    (ext_en),
    .ext_clr   (ext_clr),
    .sw_clr    (sw_clr),
    .out_dis   (out_dis),
    .ld_cur    (ld_cur),
    .cur_val   (cur_val),
    .match_q   (match_q),
    .coin      (coin),
    .carry     (carry),
    .ack       (ack),
    .nak       (nak)
);

// File: tb/cyc_match_counter_tb.sv
module cyc_match_counter_tb;
    localparam int W  = 20;
    localparam int NV = 44;

    // Ops: 0 idle, 1 step, 2 ld_cur, 3 ld_match, 4 ld_width, 5 sw_clr,
    // 6 out_dis, 7 pulse without cnt_en, 8 pulse without ext_en,
    // 9 ext_clr with pulse, 10 step with out_dis, 11 ld_cur during ext_clr
    // Entry: {op, data, exp_cur, exp_coin, exp_carry, exp_ack, exp_nak}
    localparam logic [47:0] VEC [NV] = '{
        {4'd0,  20'd0,       20'd0,      4'b0000},  // idle after reset
        {4'd2,  20'd2000,    20'd2000,   4'b0010},  // R1 default width 2000
        {4'd2,  20'd2001,    20'd2000,   4'b0001},  // R10 above width
        {4'd3,  20'd2000,    20'd2000,   4'b0001},  // R8 not below width
        {4'd1,  20'd0,       20'd0,      4'b0100},  // R3 wrap at width
        {4'd3,  20'd3,       20'd0,      4'b0010},
        {4'd4,  20'd5,       20'd0,      4'b0010},
        {4'd4,  20'd0,       20'd0,      4'b0001},  // R9 zero width
        {4'd4,  20'd3,       20'd0,      4'b0001},  // R9 not above match
        {4'd3,  20'd5,       20'd0,      4'b0001},  // R8 equal width
        {4'd1,  20'd0,       20'd1,      4'b0000},
        {4'd1,  20'd0,       20'd2,      4'b0000},
        {4'd1,  20'd0,       20'd3,      4'b1000},  // R4 hit
        {4'd7,  20'd0,       20'd3,      4'b1000},  // R2 no cnt_en
        {4'd8,  20'd0,       20'd3,      4'b1000},  // R2 no ext_en
        {4'd0,  20'd0,       20'd3,      4'b1000},
        {4'd1,  20'd0,       20'd4,      4'b1000},
        {4'd1,  20'd0,       20'd5,      4'b1000},
        {4'd1,  20'd0,       20'd0,      4'b0100},  // R3 wrap, R4 cleared
        {4'd0,  20'd0,       20'd0,      4'b0000},  // R3 carry one cycle
        {4'd2,  20'd4,       20'd4,      4'b0010},
        {4'd2,  20'd6,       20'd4,      4'b0001},  // R10
        {4'd1,  20'd0,       20'd5,      4'b0000},
        {4'd1,  20'd0,       20'd0,      4'b0100},
        {4'd1,  20'd0,       20'd1,      4'b0000},
        {4'd1,  20'd0,       20'd2,      4'b0000},
        {4'd1,  20'd0,       20'd3,      4'b1000},
        {4'd6,  20'd0,       20'd3,      4'b0000},  // R5 clear flag
        {4'd2,  20'd2,       20'd2,      4'b0010},
        {4'd10, 20'd0,       20'd3,      4'b0000},  // R5 blocked
        {4'd1,  20'd0,       20'd4,      4'b0000},
        {4'd1,  20'd0,       20'd5,      4'b0000},
        {4'd1,  20'd0,       20'd0,      4'b0100},
        {4'd1,  20'd0,       20'd1,      4'b0000},
        {4'd1,  20'd0,       20'd2,      4'b0000},
        {4'd1,  20'd0,       20'd3,      4'b1000},
        {4'd5,  20'd0,       20'd0,      4'b0000},  // R6 sw clear
        {4'd9,  20'd0,       20'd0,      4'b0000},  // R6 ext clear
        {4'd11, 20'd4,       20'd0,      4'b0001},  // R6 load during clear
        {4'd4,  20'd1000000, 20'd0,      4'b0001},  // R11 above max
        {4'd4,  20'd999999,  20'd0,      4'b0010},  // R11 at max
        {4'd2,  20'd999999,  20'd999999, 4'b0010},
        {4'd1,  20'd0,       20'd0,      4'b0100},  // R11 wrap at max
        {4'd2,  20'd1000000, 20'd0,      4'b0001}   // R11 R10
    };

    logic clk = 1'b0;
    logic rst_n, cnt_pulse, cnt_en, ext_en, ext_clr, sw_clr, out_dis;
    logic ld_cur, ld_match, ld_width;
    logic [W-1:0] ld_data, cur_val;
    logic coin, carry, ack, nak;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cyc_match_counter u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse), .cnt_en(cnt_en),
        .ext_en(ext_en), .ext_clr(ext_clr), .sw_clr(sw_clr), .out_dis(out_dis),
        .ld_cur(ld_cur), .ld_match(ld_match), .ld_width(ld_width),
        .ld_data(ld_data), .cur_val(cur_val), .coin(coin), .carry(carry),
        .ack(ack), .nak(nak)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd2:        return "R10";
            4'd3:        return "R8";
            4'd4:        return "R9";
            4'd5, 4'd9,
            4'd11:       return "R6";
            4'd6, 4'd10: return "R5";
            default:     return "R2";
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [W-1:0] d);
        cnt_pulse = (op == 1) || (op == 7) || (op == 8) || (op == 9) || (op == 10);
        cnt_en    = (op != 7);
        ext_en    = (op != 8);
        ext_clr   = (op == 9) || (op == 11);
        sw_clr    = (op == 5);
        out_dis   = (op == 6) || (op == 10);
        ld_cur    = (op == 2) || (op == 11);
        ld_match  = (op == 3);
        ld_width  = (op == 4);
        ld_data   = d;
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        drive(4'd0, '0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "cur", cur_val, 0);
        check("R1", "coin", W'(coin), 0);
        check("R1", "carry", W'(carry), 0);
        check("R1", "ack", W'(ack), 0);
        check("R1", "nak", W'(nak), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            op = VEC[i][47:44];
            if (op == 2 || op == 3 || op == 4 || op == 11) begin
                drive(4'd0, '0);
                @(negedge clk);
            end
            drive(op, VEC[i][43:24]);
            @(negedge clk);
            check(op_tag(op), "cur", cur_val, VEC[i][23:4]);
            check("R4", "coin", W'(coin), W'(VEC[i][3]));
            check("R3", "carry", W'(carry), W'(VEC[i][2]));
            check("R7", "ack", W'(ack), W'(VEC[i][1]));
            check("R7", "nak", W'(nak), W'(VEC[i][0]));
        end

        // R7 held strobe loads once: second cycle gives no answer
        drive(4'd0, '0);
        @(negedge clk);
        drive(4'd3, 20'd7);
        @(negedge clk);
        check("R7", "ack first", W'(ack), 1);
        drive(4'd3, 20'd2000000 % 1000000);
        @(negedge clk);
        check("R7", "ack held", W'(ack), 0);
        check("R7", "nak held", W'(nak), 0);

        // R1 mid-run reset restores defaults (match 1000, width 2000)
        drive(4'd1, '0);
        repeat (3) @(negedge clk);
        drive(4'd0, '0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "cur after reset", cur_val, 0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(4'd4, 20'd1000);
        @(negedge clk);
        check("R1", "nak width=default match", W'(nak), 1);
        drive(4'd0, '0);
        @(negedge clk);
        drive(4'd3, 20'd1999);
        @(negedge clk);
        check("R1", "ack match<default width", W'(ack), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule